// File: doc/BRIEF.md
# Synchronous Two-Port Static Memory

This block is a word-addressed memory with two fully independent access ports, called left and right, each running on its own clock. On every rising edge a port samples its two chip selects, its direction bit, its address and its write word. A selected port either stores the write word or fetches the addressed word. Either port may reach any location at any time, including the location the other port is using in the same cycle.

Each port has a static mode input that sets its read latency. In the short mode the fetched word is shown in the cycle right after the sampling edge. In the long mode the word passes through one more register and is shown one cycle later. Read data leaves on a plain output bus with a qualifying valid flag instead of a bidirectional pin. The output enable is asynchronous and gates only the valid flag.

The default depth is 4096 words of 9 bits. Setting `ADDR_W` to 16 gives the full 64K organisation. Setting `IGNORE_TOP` builds the half-depth variant, which discards the top address bit.

Top module: `dpr_core`

## Requirements
- R1: A port is deselected when its `cs0_n` is 1 or its `cs1` is 0. A deselected port stores nothing. In the cycle after a deselected edge, the short-latency valid flag of that port is 0.
- R2: A selected port with `rnw` = 0 at a rising edge stores its `wdata` at its `addr`. A later read of that address from either port returns the stored word.
- R3: A selected port with `rnw` = 1 at a rising edge fetches the addressed word. `rvalid` is 1 for that word only while `oe_n` is 0.
- R4: `oe_n` acts without a clock. Raising it drops `rvalid` at once, and lowering it during a valid cycle raises `rvalid` at once.
- R5: With `pipe` = 0, the word fetched at edge n is on `rdata` with `rvalid` = 1 from edge n until edge n+1.
- R6: With `pipe` = 1, the word fetched at edge n is on `rdata` with `rvalid` = 1 from edge n+1 until edge n+2.
- R7: With `pipe` = 1, `rdata` keeps its last fetched word through cycles with no read, including deselected cycles.
- R8: Both ports may read the same address at the same edge, and both get the same word.
- R9: When one port writes an address at the same edge the other port reads it, the reader gets the contents from before that write.
- R10: When both ports write the same address at the same edge, the left port's word is kept.
- R11: With `IGNORE_TOP` = 1, the top address bit is discarded, so addresses that differ only in that bit name the same word.
- R12: A write cycle yields no valid output. Its latency stage shows `rvalid` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_l | input | 1 | Left port clock |
| clk_r | input | 1 | Right port clock |
| rst_n | input | 1 | Asynchronous active-low reset of the valid stages |
| cs0_n_l | input | 1 | Left chip select, active low |
| cs1_l | input | 1 | Left chip select, active high |
| rnw_l | input | 1 | Left direction: 1 read, 0 write |
| oe_n_l | input | 1 | Left asynchronous output enable, active low |
| pipe_l | input | 1 | Left latency mode: 0 short, 1 long |
| addr_l | input | ADDR_W | Left word address |
| wdata_l | input | DATA_W | Left write word |
| rdata_l | output | DATA_W | Left read word |
| rvalid_l | output | 1 | Left read word valid and enabled |
| cs0_n_r | input | 1 | Right chip select, active low |
| cs1_r | input | 1 | Right chip select, active high |
| rnw_r | input | 1 | Right direction: 1 read, 0 write |
| oe_n_r | input | 1 | Right asynchronous output enable, active low |
| pipe_r | input | 1 | Right latency mode: 0 short, 1 long |
| addr_r | input | ADDR_W | Right word address |
| wdata_r | input | DATA_W | Right write word |
| rdata_r | output | DATA_W | Right read word |
| rvalid_r | output | 1 | Right read word valid and enabled |

## Verification
The bench targets the same-edge collisions. A design that forwards new data to a colliding reader returns the fresh word where the old one is due. A design with no write priority keeps the right port's word, or a blend of the two, at a doubly written address. The bench also checks that each latency mode shows each word in exactly one cycle: a one-cycle slip in the long mode shifts every word and fails each compare in a burst. Writes issued while deselected are read back afterwards, and the long-mode output is watched through idle and deselected cycles, so a stray store or a register that reloads on every edge shows up as changed data. The output enable is toggled between clock edges to catch a registered enable.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

  // A port is live only with its low-true select low and its high-true select high
  function automatic logic chip_sel(input logic cs0_n, input logic cs1);
    return (!cs0_n) && cs1;
  endfunction

  // Live-value tag rule: equal tags mean the left copy holds the newest word
  function automatic logic left_is_newest(input logic tag_left, input logic tag_right);
    return tag_left == tag_right;
  endfunction

endpackage

// File: rtl/dpr_store.sv
module dpr_store #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 9
) (
  input  logic              clk_l,
  input  logic              clk_r,
  input  logic              rst_n,
  input  logic              wr_l,
  input  logic              rd_l,
  input  logic [ADDR_W-1:0] a_l,
  input  logic [DATA_W-1:0] wd_l,
  output logic [DATA_W-1:0] rq_l,
  input  logic              wr_r,
  input  logic              rd_r,
  input  logic [ADDR_W-1:0] a_r,
  input  logic [DATA_W-1:0] wd_r,
  output logic [DATA_W-1:0] rq_r
);
  localparam int DEPTH = 1 << ADDR_W;

  // one data copy per writer, plus a tag bit per word per writer
  logic [DATA_W-1:0] dat_l [DEPTH];
  logic [DATA_W-1:0] dat_r [DEPTH];
  logic              tag_l [DEPTH];
  logic              tag_r [DEPTH];

  // named events for the checks
  logic clash;
  logic wr_r_eff;
  assign clash    = wr_l && wr_r && (a_l == a_r);
  assign wr_r_eff = wr_r && !clash;

  always_ff @(posedge clk_l) begin
    if (wr_l) begin
      dat_l[a_l] <= wd_l;
      tag_l[a_l] <= tag_r[a_l];
    end
    if (rd_l)
      rq_l <= dpr_pkg::left_is_newest(tag_l[a_l], tag_r[a_l]) ? dat_l[a_l] : dat_r[a_l];
  end

  always_ff @(posedge clk_r) begin
    if (wr_r_eff) begin
      dat_r[a_r] <= wd_r;
      tag_r[a_r] <= !tag_l[a_r];
    end
    if (rd_r)
      rq_r <= dpr_pkg::left_is_newest(tag_l[a_r], tag_r[a_r]) ? dat_l[a_r] : dat_r[a_r];
  end

  // R2: after a left store the tags name the left copy as newest
  p_left_store_newest_r2: assert property (@(posedge clk_l) disable iff (!rst_n)
    wr_l |=> dpr_pkg::left_is_newest(tag_l[$past(a_l)], tag_r[$past(a_l)]));

  // R10: on a same-address double write the left copy must be the newest afterwards
  p_double_write_left_r10: assert property (@(posedge clk_l) disable iff (!rst_n)
    clash |=> dpr_pkg::left_is_newest(tag_l[$past(a_l)], tag_r[$past(a_l)]));

  // R2: after an accepted right store the tags name the right copy as newest
  p_right_store_newest_r2: assert property (@(posedge clk_r) disable iff (!rst_n)
    wr_r_eff |=> !dpr_pkg::left_is_newest(tag_l[$past(a_r)], tag_r[$past(a_r)]));

endmodule

// File: rtl/dpr_port.sv
module dpr_port #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs0_n,
  input  logic              cs1,
  input  logic              rnw,
  input  logic              oe_n,
  input  logic              pipe,
  input  logic [DATA_W-1:0] rq,
  output logic              rd_en,
  output logic              wr_en,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  logic              sel;
  logic              ft_vld;
  logic              pp_vld;
  logic [DATA_W-1:0] pp_dat;

  assign sel   = dpr_pkg::chip_sel(cs0_n, cs1);
  assign rd_en = sel && rnw;
  assign wr_en = sel && !rnw;

  // short-latency valid follows the fetch register in the store
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ft_vld <= 1'b0;
      pp_vld <= 1'b0;
    end else begin
      ft_vld <= rd_en;
      pp_vld <= ft_vld;
    end
  end

  // long-latency data register loads only behind a real fetch
  always_ff @(posedge clk) begin
    if (ft_vld) pp_dat <= rq;
  end

  assign rdata  = pipe ? pp_dat : rq;
  assign rvalid = (pipe ? pp_vld : ft_vld) && !oe_n;

  // R1: a deselected edge produces no short-latency word
  p_deselect_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> !ft_vld);

  // R12: a write edge produces no short-latency word
  p_write_no_word_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !ft_vld);

  // R6: the long stage lags the short stage by exactly one edge
  p_long_lag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ft_vld |=> pp_vld);

  // R7: with no word in the short stage the long register holds
  p_long_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ft_vld |=> $stable(pp_dat));

endmodule

// File: rtl/dpr_core.sv
module dpr_core #(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 9,
  parameter bit IGNORE_TOP = 1'b0
) (
  input  logic              clk_l,
  input  logic              clk_r,
  input  logic              rst_n,
  input  logic              cs0_n_l,
  input  logic              cs1_l,
  input  logic              rnw_l,
  input  logic              oe_n_l,
  input  logic              pipe_l,
  input  logic [ADDR_W-1:0] addr_l,
  input  logic [DATA_W-1:0] wdata_l,
  output logic [DATA_W-1:0] rdata_l,
  output logic              rvalid_l,
  input  logic              cs0_n_r,
  input  logic              cs1_r,
  input  logic              rnw_r,
  input  logic              oe_n_r,
  input  logic              pipe_r,
  input  logic [ADDR_W-1:0] addr_r,
  input  logic [DATA_W-1:0] wdata_r,
  output logic [DATA_W-1:0] rdata_r,
  output logic              rvalid_r
);
  localparam logic [ADDR_W-1:0] ADDR_KEEP =
    IGNORE_TOP ? {1'b0, {(ADDR_W-1){1'b1}}} : {ADDR_W{1'b1}};

  logic [ADDR_W-1:0] a_l, a_r;
  logic              rd_l, wr_l, rd_r, wr_r;
  logic [DATA_W-1:0] rq_l, rq_r;

  assign a_l = addr_l & ADDR_KEEP;
  assign a_r = addr_r & ADDR_KEEP;

  dpr_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port_l (
    .clk(clk_l), .rst_n(rst_n), .cs0_n(cs0_n_l), .cs1(cs1_l), .rnw(rnw_l),
    .oe_n(oe_n_l), .pipe(pipe_l), .rq(rq_l), .rd_en(rd_l), .wr_en(wr_l),
    .rdata(rdata_l), .rvalid(rvalid_l));

  dpr_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port_r (
    .clk(clk_r), .rst_n(rst_n), .cs0_n(cs0_n_r), .cs1(cs1_r), .rnw(rnw_r),
    .oe_n(oe_n_r), .pipe(pipe_r), .rq(rq_r), .rd_en(rd_r), .wr_en(wr_r),
    .rdata(rdata_r), .rvalid(rvalid_r));

  dpr_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk_l(clk_l), .clk_r(clk_r), .rst_n(rst_n),
    .wr_l(wr_l), .rd_l(rd_l), .a_l(a_l), .wd_l(wdata_l), .rq_l(rq_l),
    .wr_r(wr_r), .rd_r(rd_r), .a_r(a_r), .wd_r(wdata_r), .rq_r(rq_r));

endmodule

// File: tb/dpr_core_tb_top.sv
`timescale 1ns/1ps
module dpr_core_tb_top;
  localparam int AW = 12;
  localparam int DW = 9;

  logic clk = 1'b0;
  always #10 clk = ~clk;
  logic rst_n;

  logic          c0n [2];
  logic          c1  [2];
  logic          rnw [2];
  logic          oen [2];
  logic          pp  [2];
  logic [AW-1:0] ad  [2];
  logic [DW-1:0] wd  [2];
  logic [DW-1:0] rd_l, rd_r;
  logic          rv_l, rv_r;

  dpr_core #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk_l(clk), .clk_r(clk), .rst_n(rst_n),
    .cs0_n_l(c0n[0]), .cs1_l(c1[0]), .rnw_l(rnw[0]), .oe_n_l(oen[0]), .pipe_l(pp[0]),
    .addr_l(ad[0]), .wdata_l(wd[0]), .rdata_l(rd_l), .rvalid_l(rv_l),
    .cs0_n_r(c0n[1]), .cs1_r(c1[1]), .rnw_r(rnw[1]), .oe_n_r(oen[1]), .pipe_r(pp[1]),
    .addr_r(ad[1]), .wdata_r(wd[1]), .rdata_r(rd_r), .rvalid_r(rv_r));

  // half-depth variant, right side parked
  logic          n_c0n, n_rnw;
  logic [AW-1:0] n_ad;
  logic [DW-1:0] n_wd, n_rd, n_rd_r;
  logic          n_rv, n_rv_r;

  dpr_core #(.ADDR_W(AW), .DATA_W(DW), .IGNORE_TOP(1'b1)) dut_n_i (
    .clk_l(clk), .clk_r(clk), .rst_n(rst_n),
    .cs0_n_l(n_c0n), .cs1_l(1'b1), .rnw_l(n_rnw), .oe_n_l(1'b0), .pipe_l(1'b0),
    .addr_l(n_ad), .wdata_l(n_wd), .rdata_l(n_rd), .rvalid_l(n_rv),
    .cs0_n_r(1'b1), .cs1_r(1'b1), .rnw_r(1'b1), .oe_n_r(1'b0), .pipe_r(1'b0),
    .addr_r('0), .wdata_r('0), .rdata_r(n_rd_r), .rvalid_r(n_rv_r));

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // behavioural reference: dictionary memory plus two latency stages per port
  logic [DW-1:0] mdl [int];
  bit            ftv [2], ppv [2], ftk [2], ppk [2];
  logic [DW-1:0] ftd [2], ppd [2];
  bit            m_rd [2], m_wr [2];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < 2; p++) begin
        ftv[p] = 0; ppv[p] = 0; ftk[p] = 0; ppk[p] = 0;
      end
    end else begin
      for (int p = 0; p < 2; p++) begin
        m_rd[p] = !c0n[p] && c1[p] && rnw[p];
        m_wr[p] = !c0n[p] && c1[p] && !rnw[p];
        ppv[p] = ftv[p];
        if (ftv[p]) begin ppd[p] = ftd[p]; ppk[p] = ftk[p]; end
        ftv[p] = m_rd[p];
        if (m_rd[p]) begin
          ftk[p] = mdl.exists(int'(ad[p]));
          if (ftk[p]) ftd[p] = mdl[int'(ad[p])];
        end
      end
      if (m_wr[1] && !(m_wr[0] && ad[0] == ad[1])) mdl[int'(ad[1])] = wd[1];
      if (m_wr[0]) mdl[int'(ad[0])] = wd[0];
    end
  end

  task automatic check_port(input int p, input logic av, input logic [DW-1:0] adat, input string t);
    bit ev, k;
    logic [DW-1:0] ed;
    ev = (pp[p] ? ppv[p] : ftv[p]) && !oen[p];
    k  = pp[p] ? ppk[p] : ftk[p];
    ed = pp[p] ? ppd[p] : ftd[p];
    n_chk++;
    if (av !== ev) begin
      n_fail++;
      $display("FAIL %s port%0d rvalid act %b exp %b", t, p, av, ev);
    end
    if (k) begin
      n_chk++;
      if (adat !== ed) begin
        n_fail++;
        $display("FAIL %s port%0d rdata act %h exp %h", t, p, adat, ed);
      end
    end
  endtask

  task automatic step(input string t);
    @(posedge clk);
    @(negedge clk);
    check_port(0, rv_l, rd_l, t);
    check_port(1, rv_r, rd_r, t);
  endtask

  task automatic setp(input int p, input logic s0n, input logic s1, input logic r,
                      input logic [AW-1:0] a, input logic [DW-1:0] d);
    c0n[p] = s0n; c1[p] = s1; rnw[p] = r; ad[p] = a; wd[p] = d;
  endtask

  task automatic direct(input bit cond, input string msg, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s act %h exp %h", msg, act, exp);
    end
  endtask

  initial begin
    rst_n = 0;
    for (int p = 0; p < 2; p++) begin
      setp(p, 1, 1, 1, '0, '0); oen[p] = 0; pp[p] = 0;
    end
    n_c0n = 1; n_rnw = 1; n_ad = '0; n_wd = '0;
    repeat (3) @(negedge clk);
    // reset state: nothing valid on either port
    direct(rv_l === 1'b0 && rv_r === 1'b0, "R3 reset rvalid", {8'd0, rv_l}, '0);
    rst_n = 1;
    step("R1 idle deselected");

    // R2 R12: fill, left low half, right high half, concurrent writes
    for (int i = 0; i < 8; i++) begin
      setp(0, 0, 1, 0, AW'(i), DW'(9'h100 + i));
      setp(1, 0, 1, 0, AW'(i + 8), DW'(9'h040 + 3 * i));
      step("R12 write gives no word");
    end
    // R1: writes attempted while deselected, each select in turn
    setp(0, 0, 0, 0, AW'(3), 9'h1FF);
    setp(1, 1, 1, 0, AW'(9), 9'h1FF);
    step("R1 deselected write");
    setp(0, 1, 0, 0, AW'(4), 9'h1EE);
    setp(1, 1, 0, 0, AW'(10), 9'h1EE);
    step("R1 deselected write");

    // R3 R5 R8: short-latency reads, crossing order, same address at i==5
    for (int i = 0; i < 16; i++) begin
      setp(0, 0, 1, 1, AW'(i), '0);
      setp(1, 0, 1, 1, AW'(i == 5 ? 5 : 15 - i), '0);
      step(i == 5 ? "R8 same address read" : "R5 short latency read");
    end
    // R3: output enable high hides the word
    setp(0, 0, 1, 1, AW'(2), '0); oen[0] = 1;
    step("R3 oe high hides word");
    oen[0] = 0;
    // R4: toggle enable between edges
    setp(0, 0, 1, 1, AW'(6), '0);
    step("R4 read before toggle");
    oen[0] = 1; #2;
    direct(rv_l === 1'b0, "R4 async disable", {8'd0, rv_l}, '0);
    oen[0] = 0; #2;
    direct(rv_l === 1'b1, "R4 async enable", {8'd0, rv_l}, 9'd1);

    // R6: long-latency burst on both ports
    pp[0] = 1; pp[1] = 1;
    for (int i = 0; i < 8; i++) begin
      setp(0, 0, 1, 1, AW'(i), '0);
      setp(1, 0, 1, 1, AW'(i + 8), '0);
      step("R6 long latency read");
    end
    // R7: hold through deselected and write cycles
    setp(0, 1, 1, 1, '0, '0); setp(1, 0, 0, 1, '0, '0);
    step("R7 hold deselected");
    step("R7 hold deselected");
    setp(0, 0, 1, 0, AW'(20), 9'h0F0); setp(1, 1, 1, 1, '0, '0);
    step("R7 hold across write");
    step("R7 hold idle");

    // R9: write/read collision both directions, mixed modes
    pp[0] = 0; pp[1] = 1;
    setp(0, 0, 1, 0, AW'(2), 9'h0C3); setp(1, 0, 1, 1, AW'(2), '0);
    step("R9 right reads old");
    setp(0, 0, 1, 1, AW'(9), '0); setp(1, 0, 1, 0, AW'(9), 9'h13C);
    step("R9 left reads old");
    setp(0, 0, 1, 1, AW'(9), '0); setp(1, 0, 1, 1, AW'(2), '0);
    step("R9 new word after collision");
    setp(0, 1, 1, 1, '0, '0); setp(1, 1, 1, 1, '0, '0);
    step("R9 drain");

    // R10: double write, then read from both ports
    setp(0, 0, 1, 0, AW'(4), 9'h0AA); setp(1, 0, 1, 0, AW'(4), 9'h155);
    step("R10 double write");
    setp(0, 0, 1, 1, AW'(4), '0); setp(1, 0, 1, 1, AW'(4), '0);
    step("R10 left word kept");
    setp(0, 1, 1, 1, '0, '0); setp(1, 1, 1, 1, '0, '0);
    step("R10 left word kept");
    step("R2 idle");

    // R11: half-depth variant aliases the top address bit
    n_c0n = 0; n_rnw = 0; n_ad = 12'h805; n_wd = 9'h1A5;
    @(posedge clk); @(negedge clk);
    n_rnw = 1; n_ad = 12'h005;
    @(posedge clk); @(negedge clk);
    direct(n_rv === 1'b1, "R11 alias valid", {8'd0, n_rv}, 9'd1);
    direct(n_rd === 9'h1A5, "R11 alias data", n_rd, 9'h1A5);
    n_c0n = 1;

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired act running exp done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule